// File: doc/BRIEF.md
# I2C Master Register and Event-Status Unit

This block is the register file that sits between a 32-bit memory-mapped bus and the byte engine of an I2C master. It stores the configuration bytes that the sequencer and the bit-clock divider consume: control, clock divider low and high parts, own address parts and the data byte. It also gathers the event pulses that the byte engine raises into two status views. A summary event flag is derived from those sticky bits, and a level interrupt is raised when that flag is set and software has enabled interrupts.

Every register is one byte wide and sits at a word-aligned offset. A write is honoured only when the byte is repeated in both halfwords of the bus word. A read returns the byte in both halfwords. Several status bits clear as a side effect of register traffic: reading a status view, reading or writing the data byte, or writing the control byte. This lets a driver acknowledge events without separate clear registers. Pin timing and slave operation are handled elsewhere.

Top module: `i2c_csr_unit`

## Requirements
- R1: After reset every register reads 0x00 except own-address part 2, which reads 0x40, and `irq` is low.
- R2: Byte addresses select: 0x00 control, 0x04 status view 1, 0x08 status view 2, 0x0C clock divider low, 0x10 own address part 1, 0x14 own address part 2, 0x18 data, 0x1C clock divider high. A read at an address with bits [1:0] nonzero or at 0x20 or above returns all zeros.
- R3: A write changes a register, or causes a clear, only when `bus_wdata[7:0]` equals `bus_wdata[23:16]`. Any other write has no effect.
- R4: A mapped read returns the register byte in bits [7:0] and again in bits [23:16], with bits [31:24] and [15:8] zero. With no read in progress `bus_rdata` is zero.
- R5: Writes to both status views are ignored. Status view 2 bit 6 always reads 0. Own address part 2 keeps only bits 7:5 and 2:1. Clock divider high keeps only bits 4:0. Unkept bits read 0.
- R6: A pulse on `ev_stat1` bit 6, 3, 2 or 0, or on `ev_stat2` bit 7, 5, 4, 3, 2, 1 or 0, sets the same bit of the matching status view until it is cleared. Other input bits are ignored. Status view 1 bits 5, 4 and 1 show `lvl_tx`, `lvl_busy` and `lvl_master` directly.
- R7: Status view 1 bit 7 is the OR of all sticky bits of both views.
- R8: `irq` equals status view 1 bit 7 AND control bit 0.
- R9: An accepted data write clears status view 1 bits 3 and 6 and pulses `tx_load` in the same cycle. A data read clears status view 1 bit 3.
- R10: An accepted control write clears status view 2 bit 5.
- R11: Reading status view 1 clears its bits 2 and 0. Reading status view 2 clears its bits 7, 4, 3, 2, 1 and 0 (not bit 5).
- R12: When an event pulse and a clearing access hit the same bit in the same cycle, the bit ends set.
- R13: `rx_valid` loads `rx_byte` into the data register, and wins over a bus write to it in the same cycle.
- R14: `ctrl_q` is the control byte and `tx_byte` the data byte. `clk_div` is {divider high [4:0], divider low [6:0]}, `fast_mode` is divider low bit 7, `own_addr` is {own part 2 [2:1], own part 1}, and `freq_sel` is own part 2 [7:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write word, byte repeated in both halfwords |
| bus_rdata | output | 32 | Read word, same cycle as the access |
| ev_stat1 | input | 8 | Event pulses for status view 1 |
| ev_stat2 | input | 8 | Event pulses for status view 2 |
| lvl_tx | input | 1 | Transmitter-mode level |
| lvl_busy | input | 1 | Bus-busy level |
| lvl_master | input | 1 | Master-mode level |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Level interrupt |
| ctrl_q | output | 8 | Control byte |
| tx_byte | output | 8 | Data byte |
| tx_load | output | 1 | Accepted data write strobe |
| clk_div | output | 12 | Bit-clock divider |
| fast_mode | output | 1 | Fast-mode select |
| own_addr | output | 10 | Own address |
| freq_sel | output | 3 | Input clock range select |

## Verification
The bench goes after the side-effect clears and the same-cycle races around them. If set did not win over clear, an event arriving while a status read is in progress would be lost and the interrupt would never rise. If the lane check were skipped, a mismatched write would alter configuration or silently clear the address-phase bit. If status view 2 were cleared whole on read, bit 5 would vanish without a control write. If the data-register priority were reversed, a received byte would be overwritten by a concurrent software write. Mixed random traffic also covers unmapped and misaligned offsets, which a loose decode would alias onto real registers.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int REG_W    = 8;
    localparam int BUS_W    = 32;
    localparam int HALF_W   = BUS_W / 2;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int CC_LO_W  = 7;
    localparam int CC_HI_W  = 5;
    localparam int DIV_W    = CC_LO_W + CC_HI_W;
    localparam int OWN_W    = REG_W + 2;
    localparam int FSEL_W   = 3;

    typedef enum logic [IDX_W-1:0] {
        RI_CTRL  = 3'd0,
        RI_STAT1 = 3'd1,
        RI_STAT2 = 3'd2,
        RI_CLKLO = 3'd3,
        RI_OWN1  = 3'd4,
        RI_OWN2  = 3'd5,
        RI_DATA  = 3'd6,
        RI_CLKHI = 3'd7
    } reg_idx_e;

    // sticky bits in each status view
    localparam logic [REG_W-1:0] S1_STICKY = 8'h4D;
    localparam logic [REG_W-1:0] S2_STICKY = 8'hBF;
    // side-effect clear masks
    localparam logic [REG_W-1:0] S1_RD_CLR   = 8'h05;
    localparam logic [REG_W-1:0] S1_DRD_CLR  = 8'h08;
    localparam logic [REG_W-1:0] S1_DWR_CLR  = 8'h48;
    localparam logic [REG_W-1:0] S2_RD_CLR   = 8'h9F;
    localparam logic [REG_W-1:0] S2_CWR_CLR  = 8'h20;

    typedef logic [NUM_REGS-1:0][REG_W-1:0] reg_bank_t;

    function automatic logic [REG_W-1:0] slot_reset(int idx);
        return (idx == int'(RI_OWN2)) ? 8'h40 : 8'h00;
    endfunction

    function automatic logic [REG_W-1:0] slot_mask(int idx);
        case (idx)
            int'(RI_OWN2):  return 8'hE6;
            int'(RI_CLKHI): return 8'h1F;
            default:        return 8'hFF;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] dup_byte(logic [REG_W-1:0] v);
        return {{(HALF_W-REG_W){1'b0}}, v, {(HALF_W-REG_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/i2cr_decode.sv
module i2cr_decode
    import i2cr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [NUM_REGS-1:0] wr_stb,
    output logic [NUM_REGS-1:0] rd_stb,
    output logic [REG_W-1:0]    wbyte
);
    localparam int IDX_LSB = 2;
    localparam int TOP_LSB = IDX_LSB + IDX_W;

    logic     hi_zero;
    logic     mapped;
    logic     lanes_eq;
    reg_idx_e idx;

    generate
        if (ADDR_W > TOP_LSB) begin : g_hi
            assign hi_zero = (bus_addr[ADDR_W-1:TOP_LSB] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign idx      = reg_idx_e'(bus_addr[TOP_LSB-1:IDX_LSB]);
    assign mapped   = hi_zero && (bus_addr[IDX_LSB-1:0] == '0);
    assign lanes_eq = (bus_wdata[REG_W-1:0] == bus_wdata[HALF_W+REG_W-1:HALF_W]);
    assign wbyte    = bus_wdata[REG_W-1:0];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_stb
            assign wr_stb[i] = bus_sel && bus_wr && mapped && lanes_eq && (int'(idx) == i);
            assign rd_stb[i] = bus_sel && !bus_wr && mapped && (int'(idx) == i);
        end
    endgenerate

endmodule

// File: rtl/i2cr_cfg_regs.sv
module i2cr_cfg_regs
    import i2cr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] wr_stb,
    input  logic [REG_W-1:0]    wbyte,
    input  logic                rx_valid,
    input  logic [REG_W-1:0]    rx_byte,
    output reg_bank_t           q
);
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
            if (i == int'(RI_STAT1) || i == int'(RI_STAT2)) begin : g_view
                assign q[i] = '0;
            end else if (i == int'(RI_DATA)) begin : g_data
                logic [REG_W-1:0] r;
                always_ff @(posedge clk) begin
                    if (rst)            r <= slot_reset(i);
                    else if (rx_valid)  r <= rx_byte;
                    else if (wr_stb[i]) r <= wbyte;
                end
                assign q[i] = r;
            end else begin : g_cfg
                logic [REG_W-1:0] r;
                always_ff @(posedge clk) begin
                    if (rst)            r <= slot_reset(i);
                    else if (wr_stb[i]) r <= wbyte & slot_mask(i);
                end
                assign q[i] = r;
            end
        end
    endgenerate

endmodule

// File: rtl/i2cr_events.sv
module i2cr_events
    import i2cr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ev_stat1,
    input  logic [REG_W-1:0] ev_stat2,
    input  logic             lvl_tx,
    input  logic             lvl_busy,
    input  logic             lvl_master,
    input  logic             rd_stat1,
    input  logic             rd_stat2,
    input  logic             rd_data,
    input  logic             wr_data,
    input  logic             wr_ctrl,
    output logic [REG_W-1:0] flag1_q,
    output logic [REG_W-1:0] flag2_q,
    output logic [REG_W-1:0] view1,
    output logic [REG_W-1:0] view2,
    output logic             evf
);
    logic [REG_W-1:0] clr1, clr2;

    always_comb begin
        clr1 = '0;
        clr2 = '0;
        if (rd_stat1) clr1 |= S1_RD_CLR;
        if (rd_data)  clr1 |= S1_DRD_CLR;
        if (wr_data)  clr1 |= S1_DWR_CLR;
        if (rd_stat2) clr2 |= S2_RD_CLR;
        if (wr_ctrl)  clr2 |= S2_CWR_CLR;
    end

    // an arriving pulse outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag1_q <= '0;
            flag2_q <= '0;
        end else begin
            flag1_q <= ((flag1_q & ~clr1) | ev_stat1) & S1_STICKY;
            flag2_q <= ((flag2_q & ~clr2) | ev_stat2) & S2_STICKY;
        end
    end

    assign evf   = (|flag1_q) || (|flag2_q);
    assign view1 = {evf, flag1_q[6], lvl_tx, lvl_busy, flag1_q[3], flag1_q[2], lvl_master, flag1_q[0]};
    assign view2 = flag2_q & S2_STICKY;

endmodule

// File: rtl/i2c_csr_unit.sv
module i2c_csr_unit
    import i2cr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        ev_stat1,
    input  logic [7:0]        ev_stat2,
    input  logic              lvl_tx,
    input  logic              lvl_busy,
    input  logic              lvl_master,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              irq,
    output logic [7:0]        ctrl_q,
    output logic [7:0]        tx_byte,
    output logic              tx_load,
    output logic [11:0]       clk_div,
    output logic              fast_mode,
    output logic [9:0]        own_addr,
    output logic [2:0]        freq_sel
);
    logic [NUM_REGS-1:0] wr_stb, rd_stb;
    logic [REG_W-1:0]    wbyte;
    reg_bank_t           store;
    reg_bank_t           view;
    logic [REG_W-1:0]    flag1_q, flag2_q, view1, view2;
    logic                evf;
    logic [REG_W-1:0]    rd_val;

    i2cr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .wbyte     (wbyte)
    );

    i2cr_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wbyte    (wbyte),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .q        (store)
    );

    i2cr_events u_evt (
        .clk        (clk),
        .rst        (rst),
        .ev_stat1   (ev_stat1),
        .ev_stat2   (ev_stat2),
        .lvl_tx     (lvl_tx),
        .lvl_busy   (lvl_busy),
        .lvl_master (lvl_master),
        .rd_stat1   (rd_stb[RI_STAT1]),
        .rd_stat2   (rd_stb[RI_STAT2]),
        .rd_data    (rd_stb[RI_DATA]),
        .wr_data    (wr_stb[RI_DATA]),
        .wr_ctrl    (wr_stb[RI_CTRL]),
        .flag1_q    (flag1_q),
        .flag2_q    (flag2_q),
        .view1      (view1),
        .view2      (view2),
        .evf        (evf)
    );

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_view
            if (i == int'(RI_STAT1)) begin : g_s1
                assign view[i] = view1;
            end else if (i == int'(RI_STAT2)) begin : g_s2
                assign view[i] = view2;
            end else begin : g_st
                assign view[i] = store[i];
            end
        end
    endgenerate

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_stb[i]) rd_val |= view[i];
        end
    end

    assign bus_rdata = dup_byte(rd_val);
    assign irq       = evf && store[RI_CTRL][0];
    assign ctrl_q    = store[RI_CTRL];
    assign tx_byte   = store[RI_DATA];
    assign tx_load   = wr_stb[RI_DATA];
    assign clk_div   = {store[RI_CLKHI][CC_HI_W-1:0], store[RI_CLKLO][CC_LO_W-1:0]};
    assign fast_mode = store[RI_CLKLO][REG_W-1];
    assign own_addr  = {store[RI_OWN2][2:1], store[RI_OWN1]};
    assign freq_sel  = store[RI_OWN2][REG_W-1:REG_W-FSEL_W];

endmodule

// File: rtl/i2c_csr_chk.sv
module i2c_csr_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        ev_stat1,
    input logic [7:0]        ev_stat2,
    input logic              irq,
    input logic [7:0]        ctrl_q,
    input logic              tx_load,
    input logic [11:0]       clk_div,
    input logic [9:0]        own_addr,
    input logic [7:0]        flag1_q,
    input logic [7:0]        flag2_q
);
    logic lane_bad, ctrl_wr_ok;
    assign lane_bad   = bus_sel && bus_wr && (bus_wdata[7:0] != bus_wdata[23:16]);
    assign ctrl_wr_ok = bus_sel && bus_wr && (bus_addr == '0) && !lane_bad;

    assert_reject_mismatch_R3: assert property (@(posedge clk) disable iff (rst)
        lane_bad |=> ($stable(ctrl_q) && $stable(clk_div) && $stable(own_addr)));

    assert_read_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr) |-> (bus_rdata[7:0] == bus_rdata[23:16] &&
                                  bus_rdata[15:8] == 8'h00 && bus_rdata[31:24] == 8'h00));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel || bus_wr) |-> (bus_rdata == 32'h0));

    assert_evf_source_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((|flag1_q) || (|flag2_q)));

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl_q[0]);

    assert_data_wr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_load && !ev_stat1[3] && !ev_stat1[6]) |=> (!flag1_q[3] && !flag1_q[6]));

    assert_ctrl_wr_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_ok && !ev_stat2[5]) |=> !flag2_q[5]);

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        ev_stat2[4] |=> flag2_q[4]);

    assert_set_wins_s1_R12: assert property (@(posedge clk) disable iff (rst)
        ev_stat1[3] |=> flag1_q[3]);

endmodule

bind i2c_csr_unit i2c_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev_stat1  (ev_stat1),
    .ev_stat2  (ev_stat2),
    .irq       (irq),
    .ctrl_q    (ctrl_q),
    .tx_load   (tx_load),
    .clk_div   (clk_div),
    .own_addr  (own_addr),
    .flag1_q   (flag1_q),
    .flag2_q   (flag2_q)
);

// File: tb/tb_i2c_csr_unit.sv
module tb_i2c_csr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [7:0]        ev_stat1 = '0, ev_stat2 = '0;
    logic              lvl_tx = 1'b0, lvl_busy = 1'b0, lvl_master = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic              irq, tx_load, fast_mode;
    logic [7:0]        ctrl_q, tx_byte;
    logic [11:0]       clk_div;
    logic [9:0]        own_addr;
    logic [2:0]        freq_sel;

    i2c_csr_unit #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_stat1(ev_stat1), .ev_stat2(ev_stat2),
        .lvl_tx(lvl_tx), .lvl_busy(lvl_busy), .lvl_master(lvl_master),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .irq(irq), .ctrl_q(ctrl_q),
        .tx_byte(tx_byte), .tx_load(tx_load), .clk_div(clk_div), .fast_mode(fast_mode),
        .own_addr(own_addr), .freq_sel(freq_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 0;
    string cur_req = "R1";
    logic [2:0] lvl_g = 3'b000;

    // behavioural reference state
    logic [7:0] m_reg [8];
    logic [7:0] m_f1, m_f2;

    function automatic void m_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_reg[5] = 8'h40;
        m_f1 = 8'h00;
        m_f2 = 8'h00;
    endfunction

    function automatic logic [7:0] m_view(int idx, logic [2:0] l);
        logic evf;
        evf = (m_f1 != 0) || (m_f2 != 0);
        if (idx == 1) return {evf, m_f1[6], l[2], l[1], m_f1[3], m_f1[2], l[0], m_f1[0]};
        if (idx == 2) return m_f2 & 8'hBF;
        return m_reg[idx];
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic sel, input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, input logic [7:0] s1, input logic [7:0] s2,
                        input logic rv, input logic [7:0] rb, input logic [2:0] l);
        logic       mapped, okw, rd;
        int         idx;
        logic [7:0] v, c1, c2;
        logic [31:0] exp_rd;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        ev_stat1 = s1; ev_stat2 = s2; rx_valid = rv; rx_byte = rb;
        {lvl_tx, lvl_busy, lvl_master} = l;
        mapped = (a[1:0] == 2'b00) && (a < 6'h20);
        idx    = int'(a[4:2]);
        okw    = sel && wr && mapped && (d[7:0] == d[23:16]);
        rd     = sel && !wr && mapped;
        #1;
        if (!rst) begin
            vectors++;
            v = m_view(idx, l);
            exp_rd = rd ? {8'h00, v, 8'h00, v} : 32'h0;
            chk(cur_req, "rdata", bus_rdata, exp_rd);
            chk("R8", "irq", irq, ((m_f1 != 0) || (m_f2 != 0)) && m_reg[0][0]);
            chk("R9", "tx_load", tx_load, okw && idx == 6);
            chk("R14", "ctrl_q", ctrl_q, m_reg[0]);
            chk("R14", "tx_byte", tx_byte, m_reg[6]);
            chk("R14", "clk_div", clk_div, {m_reg[7][4:0], m_reg[3][6:0]});
            chk("R14", "fast_mode", fast_mode, m_reg[3][7]);
            chk("R14", "own_addr", own_addr, {m_reg[5][2:1], m_reg[4]});
            chk("R14", "freq_sel", freq_sel, m_reg[5][7:5]);
        end
        @(posedge clk);
        if (rst) begin
            m_reset();
        end else begin
            c1 = 8'h00; c2 = 8'h00;
            if (rd && idx == 1)  c1 = c1 | 8'h05;
            if (rd && idx == 6)  c1 = c1 | 8'h08;
            if (okw && idx == 6) c1 = c1 | 8'h48;
            if (rd && idx == 2)  c2 = c2 | 8'h9F;
            if (okw && idx == 0) c2 = c2 | 8'h20;
            m_f1 = ((m_f1 & ~c1) | s1) & 8'h4D;
            m_f2 = ((m_f2 & ~c2) | s2) & 8'hBF;
            if (okw) begin
                case (idx)
                    0, 3, 4: m_reg[idx] = d[7:0];
                    5:       m_reg[5] = d[7:0] & 8'hE6;
                    7:       m_reg[7] = d[7:0] & 8'h1F;
                    6:       m_reg[6] = d[7:0];
                    default: ;
                endcase
            end
            if (rv) m_reg[6] = rb;
        end
    endtask

    task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [7:0] v);
        step(1'b1, 1'b1, a, {8'h00, v, 8'h00, v}, 8'h00, 8'h00, 1'b0, 8'h00, lvl_g);
    endtask

    task automatic rd_reg(input logic [ADDR_W-1:0] a);
        step(1'b1, 1'b0, a, 32'h0, 8'h00, 8'h00, 1'b0, 8'h00, lvl_g);
    endtask

    task automatic pulse(input logic [7:0] s1, input logic [7:0] s2);
        step(1'b0, 1'b0, '0, 32'h0, s1, s2, 1'b0, 8'h00, lvl_g);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    function automatic logic [31:0] lfsr(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        m_reset();
        rst = 1'b1;
        pulse(8'h00, 8'h00);
        pulse(8'h00, 8'h00);
        rst = 1'b0;

        // R1: reset values of every slot, R2: offsets
        cur_req = "R1";
        for (int i = 0; i < 8; i++) rd_reg(ADDR_W'(i * 4));

        // R2 / R14: program configuration and read it back
        cur_req = "R2";
        wr_reg(6'h00, 8'h21);
        wr_reg(6'h0C, 8'h85);
        wr_reg(6'h10, 8'h5A);
        wr_reg(6'h18, 8'h3C);
        for (int i = 0; i < 8; i++) rd_reg(ADDR_W'(i * 4));

        // R5: masked slots and read-only views
        cur_req = "R5";
        wr_reg(6'h14, 8'hFF);
        wr_reg(6'h1C, 8'hFF);
        wr_reg(6'h04, 8'hFF);
        wr_reg(6'h08, 8'hFF);
        rd_reg(6'h14); rd_reg(6'h1C); rd_reg(6'h04); rd_reg(6'h08);

        // R2: misaligned and out-of-range reads return zero
        cur_req = "R2";
        rd_reg(6'h01); rd_reg(6'h02); rd_reg(6'h20); rd_reg(6'h3C);

        // R3: lane mismatch is ignored, including the control-write clear
        cur_req = "R3";
        pulse(8'h00, 8'h20);
        step(1'b1, 1'b1, 6'h00, 32'h0077_0011, 8'h00, 8'h00, 1'b0, 8'h00, lvl_g);
        step(1'b1, 1'b1, 6'h0C, 32'h0001_0002, 8'h00, 8'h00, 1'b0, 8'h00, lvl_g);
        rd_reg(6'h00); rd_reg(6'h08);

        // R10: accepted control write clears address-phase bit; R8 irq tracks enable
        cur_req = "R10";
        wr_reg(6'h00, 8'h20);
        rd_reg(6'h08); rd_reg(6'h04);

        // R6 / R7 / R8: events, levels and the summary flag
        cur_req = "R6";
        lvl_g = 3'b101;
        pulse(8'hFF, 8'hFF);
        rd_reg(6'h08);
        cur_req = "R7";
        wr_reg(6'h00, 8'h21);
        pulse(8'h00, 8'h00);
        lvl_g = 3'b010;
        // R11: status view reads clear their own bits
        cur_req = "R11";
        rd_reg(6'h04); rd_reg(6'h04);
        rd_reg(6'h08); rd_reg(6'h08);
        // R9: data write and data read clears
        cur_req = "R9";
        pulse(8'h48, 8'h00);
        rd_reg(6'h04);
        wr_reg(6'h18, 8'hA5);
        rd_reg(6'h04);
        pulse(8'h08, 8'h00);
        rd_reg(6'h18);
        rd_reg(6'h04);
        cur_req = "R10";
        wr_reg(6'h00, 8'h21);
        rd_reg(6'h08);
        rd_reg(6'h04);

        // R12: set and clear in the same cycle
        cur_req = "R12";
        step(1'b1, 1'b0, 6'h08, 32'h0, 8'h00, 8'h10, 1'b0, 8'h00, lvl_g);
        rd_reg(6'h08);
        step(1'b1, 1'b1, 6'h18, 32'h0011_0011, 8'h08, 8'h00, 1'b0, 8'h00, lvl_g);
        rd_reg(6'h04);
        step(1'b1, 1'b1, 6'h00, 32'h0001_0001, 8'h00, 8'h20, 1'b0, 8'h00, lvl_g);
        rd_reg(6'h08);

        // R13: received byte outranks a concurrent bus write
        cur_req = "R13";
        step(1'b1, 1'b1, 6'h18, 32'h0066_0066, 8'h00, 8'h00, 1'b1, 8'hC3, lvl_g);
        rd_reg(6'h18);
        step(1'b0, 1'b0, 6'h00, 32'h0, 8'h00, 8'h00, 1'b1, 8'h7E, lvl_g);
        rd_reg(6'h18);

        // mixed traffic: R4 lanes, R6, R9, R11, R12, R13 together
        cur_req = "R4";
        r = 32'h1ACE_B00C;
        for (int k = 0; k < 600; k++) begin
            logic [ADDR_W-1:0] a;
            logic [7:0] b, s1, s2;
            r = lfsr(r); r = lfsr(r); r = lfsr(r);
            a  = r[6] ? {1'b0, r[4:2], 2'b00} : (r[7] ? 6'(r[5:0] | 6'h20) : r[5:0]);
            b  = r[23:16];
            s1 = (r[12:10] == 3'b000) ? r[31:24] : 8'h00;
            s2 = (r[15:13] == 3'b000) ? r[29:22] : 8'h00;
            step(r[8] | r[9], r[1],  a,
                 r[20] ? {8'h00, b ^ 8'h10, 8'h00, b} : {8'h00, b, 8'h00, b},
                 s1, s2, (r[21] && r[0] && r[2]), r[31:24], r[30:28]);
        end
        rst = 1'b1;
        pulse(8'h00, 8'h00);
        rst = 1'b0;
        cur_req = "R1";
        for (int i = 0; i < 8; i++) rd_reg(ADDR_W'(i * 4));
        finish_run();
    end

endmodule